// File: doc/BRIEF.md
# Slot Status Write-Back Controller

This block sits between a time-triggered bus protocol engine and a small message-buffer RAM. When a communication slot closes, the engine pulses `slot_end` and presents a description of what happened in that slot. The description covers which buffer is assigned to the slot and the buffer's kind, the receive outcome flags, the channel, whether a transmit conflict occurred, and whether a valid data frame arrived. The block holds that description and waits for the next macrotick strobe, which opens the first macrotick of the following slot. It then writes the outcome into the buffer through a masked RAM write port, one word per clock cycle.

Each buffer occupies `HDR_WORDS + PAY_WORDS + 1` consecutive RAM words. The first word is the 16-bit slot status word, and the remaining words hold the frame header and payload. The buffer kind and the frame outcome decide which words are written. A transmit buffer receives only its conflict bit. A receive buffer with a null or invalid frame receives only its status word. A receive buffer with a valid frame receives the status word followed by every data word. The data words are fetched from the engine's frame store through an index output.

A `busy`/`done` handshake shows write-back progress. A slot-end event that arrives while a write-back is pending or running is dropped, and it raises a sticky overrun flag.

Top module: `slotwb_ctrl`

## Requirements
- R1: A receive status write places the channel in bit 8 (1 = channel B) and `rx_flags[6:0]` in bits 7..1. The bits map in this order: `rx_flags[6]` to bit 7 (valid communication element), then sync, null, startup, syntax error, content error and boundary violation, down to `rx_flags[0]` in bit 1. Bits 15..9 are written as zero.
- R2: For buffer kind 2'b01 (transmit), exactly one write is issued, to the status word, with mask 16'h0001. Bit 0 carries `tx_conflict`, which the engine sets when a reception was already under way as transmission started. All other bits and all data words keep their values.
- R3: For buffer kinds 2'b10 (receive) and 2'b11 (receive FIFO), the status write uses mask 16'hFFFE, so bit 0 is never changed.
- R4: For a receive buffer with `frame_ok` low (null or invalid frame), only the status word is written and the data words keep their values.
- R5: For a receive buffer with `frame_ok` high, the status write is followed in the next cycles by `HDR_WORDS+PAY_WORDS` full-mask writes. These go to consecutive addresses starting at buffer base + 1, and write n carries `frm_data` while `frm_idx` = n. The buffer base is `buf_sel * (HDR_WORDS+PAY_WORDS+1)`, and the status word sits at offset 0.
- R6: No write occurs before a `mt_tick` that is sampled strictly after the `slot_end` cycle; a tick in the same cycle as `slot_end` does not start the write-back. The first write appears in the cycle right after the starting tick, and all writes follow back to back.
- R7: An empty slot (receive buffer, all flags zero, `frame_ok` low) leaves bits 15..1 of the status word as 16'h0000 on channel A and 16'h0100 on channel B.
- R8: `busy` is high from the cycle after an accepted `slot_end` through the last write. `done` is high for exactly one cycle, the one right after the last write.
- R9: A `slot_end` while `busy` is high is dropped and sets `overrun`, which stays set until reset.
- R10: A `slot_end` with buffer kind 2'b00 (no buffer assigned) is ignored: `busy` stays low, and no write or `done` follows.
- R11: A synchronous reset clears any pending or running write-back, `overrun`, `busy`, `done` and `ram_we` by the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| slot_end | input | 1 | One-cycle pulse when a slot closes |
| buf_kind | input | 2 | Kind of buffer tied to the slot: 00 none, 01 transmit, 10 receive, 11 receive FIFO |
| buf_sel | input | $clog2(NUM_BUFS) | Buffer number tied to the slot |
| ch_b | input | 1 | Channel of the slot, 1 = channel B |
| rx_flags | input | 7 | Receive outcome flags, written to status bits 7..1 |
| tx_conflict | input | 1 | Reception was in progress when transmission started |
| frame_ok | input | 1 | A valid data frame was received |
| mt_tick | input | 1 | Macrotick strobe |
| frm_idx | output | $clog2(HDR_WORDS+PAY_WORDS) | Index of the frame word being copied |
| frm_data | input | 16 | Frame word selected by `frm_idx` |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | $clog2(NUM_BUFS*(HDR_WORDS+PAY_WORDS+1)) | RAM word address |
| ram_wdata | output | 16 | RAM write data |
| ram_wmask | output | 16 | Per-bit write mask, 1 = write |
| busy | output | 1 | Write-back pending or running |
| done | output | 1 | One-cycle pulse after the last write |
| overrun | output | 1 | Sticky: a slot-end event was dropped |

## Verification
The bench keeps its own model of the buffer RAM and seeds it with nonzero reserved bits, so a receive write that fails to clear bits 15..9 or that touches bit 0 shows up as a corrupted word. Transmit and null-frame cases are followed by checks that the data words of the same buffer are unchanged; a design that wrote the whole buffer, or used the wrong mask, would overwrite them. A tick that coincides with `slot_end` is tested on its own, since a design that counted it would write one macrotick early. A second `slot_end` during a pending write-back and a reset in the middle of the data burst target the overrun and abort paths; a wrong design would either clobber the second buffer or keep writing after reset.

// File: rtl/slotwb_pkg.sv
package slotwb_pkg;

  typedef enum logic [1:0] {
    BK_NONE   = 2'b00,
    BK_TX     = 2'b01,
    BK_RX     = 2'b10,
    BK_RXFIFO = 2'b11
  } buf_kind_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_PEND,
    SQ_STAT,
    SQ_DATA
  } seq_state_e;

  localparam int WORD_W = 16;
  localparam int FLAG_W = 7;

  localparam logic [WORD_W-1:0] TX_MASK = 16'h0001;
  localparam logic [WORD_W-1:0] RX_MASK = 16'hFFFE;

  function automatic logic kind_is_rx(buf_kind_e k);
    return (k == BK_RX) || (k == BK_RXFIFO);
  endfunction

  // Receive status: reserved zeros, channel, seven flags, bit 0 untouched.
  function automatic logic [WORD_W-1:0] rx_status(logic ch_b, logic [FLAG_W-1:0] fl);
    return {7'b0, ch_b, fl, 1'b0};
  endfunction

  function automatic logic [WORD_W-1:0] tx_status(logic conflict);
    return {{(WORD_W-1){1'b0}}, conflict};
  endfunction

  function automatic int unsigned word_addr(int unsigned buf_i, int unsigned wpb,
                                            int unsigned offs);
    return buf_i * wpb + offs;
  endfunction

endpackage

// File: rtl/slotwb_fmt.sv
module slotwb_fmt
  import slotwb_pkg::*;
(
  input  buf_kind_e               kind,
  input  logic                    ch_b,
  input  logic [FLAG_W-1:0]       flags,
  input  logic                    tx_conf,
  output logic [WORD_W-1:0]       stat_word,
  output logic [WORD_W-1:0]       stat_mask
);

  always_comb begin
    case (kind)
      BK_TX: begin
        stat_word = tx_status(tx_conf);
        stat_mask = TX_MASK;
      end
      BK_RX, BK_RXFIFO: begin
        stat_word = rx_status(ch_b, flags);
        stat_mask = RX_MASK;
      end
      default: begin
        stat_word = '0;
        stat_mask = '0;
      end
    endcase
  end

endmodule

// File: rtl/slotwb_addr.sv
module slotwb_addr #(
  parameter int NUM_BUFS   = 8,
  parameter int WPB        = 7,
  parameter int BUF_W      = 3,
  parameter int IDX_W      = 3,
  parameter int ADDR_W     = 6
) (
  input  logic [BUF_W-1:0]  buf_q,
  input  logic              stat_phase,
  input  logic [IDX_W-1:0]  data_idx,
  output logic [ADDR_W-1:0] addr
);
  import slotwb_pkg::*;

  localparam int OFF_W    = (WPB > 1) ? $clog2(WPB) : 1;
  localparam bit WPB_POW2 = ((WPB & (WPB - 1)) == 0);

  logic [OFF_W-1:0] offs;

  always_comb begin
    if (stat_phase) offs = '0;
    else            offs = OFF_W'(data_idx) + OFF_W'(1);
  end

  generate
    if (WPB_POW2) begin : g_concat
      always_comb addr = ADDR_W'({buf_q, offs});
    end else begin : g_mult
      always_comb addr = ADDR_W'(word_addr(int'(buf_q), WPB, int'(offs)));
    end
  endgenerate

endmodule

// File: rtl/slotwb_seq.sv
module slotwb_seq
  import slotwb_pkg::*;
#(
  parameter int BUF_W      = 3,
  parameter int DATA_WORDS = 6,
  parameter int IDX_W      = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               slot_end,
  input  buf_kind_e          kind_in,
  input  logic [BUF_W-1:0]   buf_in,
  input  logic               ch_in,
  input  logic [FLAG_W-1:0]  flags_in,
  input  logic               txc_in,
  input  logic               ok_in,
  input  logic               mt_tick,
  output buf_kind_e          kind_q,
  output logic [BUF_W-1:0]   buf_q,
  output logic               ch_q,
  output logic [FLAG_W-1:0]  flags_q,
  output logic               txc_q,
  output logic               stat_phase,
  output logic               data_phase,
  output logic [IDX_W-1:0]   data_idx,
  output logic               busy,
  output logic               done,
  output logic               overrun,
  output logic               slot_accept
);

  seq_state_e state;
  logic       ok_q;
  logic       slot_drop;
  logic       need_data;
  logic       last_data;

  assign busy        = (state != SQ_IDLE);
  assign slot_accept = slot_end && !busy && (kind_in != BK_NONE);
  assign slot_drop   = slot_end && busy;
  assign stat_phase  = (state == SQ_STAT);
  assign data_phase  = (state == SQ_DATA);
  assign need_data   = kind_is_rx(kind_q) && ok_q;
  assign last_data   = (data_idx == IDX_W'(DATA_WORDS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SQ_IDLE;
      kind_q   <= BK_NONE;
      buf_q    <= '0;
      ch_q     <= 1'b0;
      flags_q  <= '0;
      txc_q    <= 1'b0;
      ok_q     <= 1'b0;
      data_idx <= '0;
      done     <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (slot_drop) overrun <= 1'b1;
      case (state)
        SQ_IDLE: begin
          if (slot_accept) begin
            kind_q  <= kind_in;
            buf_q   <= buf_in;
            ch_q    <= ch_in;
            flags_q <= flags_in;
            txc_q   <= txc_in;
            ok_q    <= ok_in;
            state   <= SQ_PEND;
          end
        end
        SQ_PEND: begin
          if (mt_tick) state <= SQ_STAT;
        end
        SQ_STAT: begin
          data_idx <= '0;
          if (need_data) begin
            state <= SQ_DATA;
          end else begin
            state <= SQ_IDLE;
            done  <= 1'b1;
          end
        end
        SQ_DATA: begin
          if (last_data) begin
            state <= SQ_IDLE;
            done  <= 1'b1;
          end else begin
            data_idx <= data_idx + IDX_W'(1);
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // R6: the cycle after acceptance never writes; the tick must come later.
  assert_defer_R6: assert property (@(posedge clk) disable iff (rst)
    slot_accept |=> !(stat_phase || data_phase));

  // R9: a slot end during a write-back raises the flag.
  assert_drop_flag_R9: assert property (@(posedge clk) disable iff (rst)
    (slot_end && busy) |=> overrun);

  // R9: the flag holds until reset.
  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

  // R8: done only right after a write cycle, with the sequencer idle.
  assert_done_follows_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(stat_phase || data_phase) && !busy));

  // R10: an event with no buffer leaves the block idle.
  assert_none_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (slot_end && !busy && kind_in == BK_NONE) |=> !busy);

endmodule

// File: rtl/slotwb_ctrl.sv
module slotwb_ctrl
  import slotwb_pkg::*;
#(
  parameter int NUM_BUFS  = 8,
  parameter int HDR_WORDS = 2,
  parameter int PAY_WORDS = 4,
  localparam int DATA_WORDS = HDR_WORDS + PAY_WORDS,
  localparam int WPB        = DATA_WORDS + 1,
  localparam int BUF_W      = (NUM_BUFS > 1) ? $clog2(NUM_BUFS) : 1,
  localparam int IDX_W      = (DATA_WORDS > 1) ? $clog2(DATA_WORDS) : 1,
  localparam int ADDR_W     = $clog2(NUM_BUFS * WPB)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slot_end,
  input  logic [1:0]        buf_kind,
  input  logic [BUF_W-1:0]  buf_sel,
  input  logic              ch_b,
  input  logic [6:0]        rx_flags,
  input  logic              tx_conflict,
  input  logic              frame_ok,
  input  logic              mt_tick,
  output logic [IDX_W-1:0]  frm_idx,
  input  logic [15:0]       frm_data,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [15:0]       ram_wdata,
  output logic [15:0]       ram_wmask,
  output logic              busy,
  output logic              done,
  output logic              overrun
);

  localparam int CNT_W = $clog2(WPB + 1);

  buf_kind_e           kind_q;
  logic [BUF_W-1:0]    buf_q;
  logic                ch_q;
  logic [FLAG_W-1:0]   flags_q;
  logic                txc_q;
  logic                stat_phase;
  logic                data_phase;
  logic [IDX_W-1:0]    data_idx;
  logic                slot_accept;
  logic [WORD_W-1:0]   stat_word;
  logic [WORD_W-1:0]   stat_mask;
  logic [CNT_W-1:0]    wr_cnt;

  slotwb_seq #(
    .BUF_W      (BUF_W),
    .DATA_WORDS (DATA_WORDS),
    .IDX_W      (IDX_W)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .slot_end    (slot_end),
    .kind_in     (buf_kind_e'(buf_kind)),
    .buf_in      (buf_sel),
    .ch_in       (ch_b),
    .flags_in    (rx_flags),
    .txc_in      (tx_conflict),
    .ok_in       (frame_ok),
    .mt_tick     (mt_tick),
    .kind_q      (kind_q),
    .buf_q       (buf_q),
    .ch_q        (ch_q),
    .flags_q     (flags_q),
    .txc_q       (txc_q),
    .stat_phase  (stat_phase),
    .data_phase  (data_phase),
    .data_idx    (data_idx),
    .busy        (busy),
    .done        (done),
    .overrun     (overrun),
    .slot_accept (slot_accept)
  );

  slotwb_fmt u_fmt (
    .kind      (kind_q),
    .ch_b      (ch_q),
    .flags     (flags_q),
    .tx_conf   (txc_q),
    .stat_word (stat_word),
    .stat_mask (stat_mask)
  );

  slotwb_addr #(
    .NUM_BUFS (NUM_BUFS),
    .WPB      (WPB),
    .BUF_W    (BUF_W),
    .IDX_W    (IDX_W),
    .ADDR_W   (ADDR_W)
  ) u_addr (
    .buf_q      (buf_q),
    .stat_phase (stat_phase),
    .data_idx   (data_idx),
    .addr       (ram_addr)
  );

  assign frm_idx   = data_idx;
  assign ram_we    = stat_phase || data_phase;
  assign ram_wdata = stat_phase ? stat_word : frm_data;
  assign ram_wmask = stat_phase ? stat_mask : '1;

  // Writes issued since the last accepted slot end, for the budget check.
  always_ff @(posedge clk) begin
    if (rst || slot_accept) wr_cnt <= '0;
    else if (ram_we)        wr_cnt <= wr_cnt + CNT_W'(1);
  end

  // R2: a transmit buffer only ever gets bit 0 of its status word.
  assert_tx_bit0_only_R2: assert property (@(posedge clk) disable iff (rst)
    (ram_we && kind_q == BK_TX) |-> (ram_wmask == 16'h0001 && (int'(ram_addr) % WPB) == 0));

  // R3 and R1: receive status keeps bit 0 and zeroes the reserved bits.
  assert_rx_status_R3: assert property (@(posedge clk) disable iff (rst)
    (stat_phase && kind_is_rx(kind_q)) |-> (!ram_wmask[0] && ram_wdata[15:9] == 7'b0));

  // R5: data words land on consecutive addresses.
  assert_addr_step_R5: assert property (@(posedge clk) disable iff (rst)
    (data_phase && $past(ram_we)) |-> (ram_addr == $past(ram_addr) + ADDR_W'(1)));

  // R5: the status word is the first write of every sequence.
  assert_status_first_R5: assert property (@(posedge clk) disable iff (rst)
    stat_phase |-> (wr_cnt == '0));

  // R6: no sequence exceeds one status word plus the data words.
  assert_write_budget_R6: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (wr_cnt < CNT_W'(WPB)));

endmodule

// File: tb/slotwb_ctrl_tb.sv
module slotwb_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_BUFS   = 8;
  localparam int HDR_WORDS  = 2;
  localparam int PAY_WORDS  = 4;
  localparam int DW         = HDR_WORDS + PAY_WORDS;
  localparam int WPB        = DW + 1;
  localparam int NWORDS     = NUM_BUFS * WPB;
  localparam int WATCHDOG   = 20000;

  typedef struct packed {
    logic [1:0] kind;
    logic [2:0] bsel;
    logic       ch;
    logic [6:0] fl;
    logic       txc;
    logic       ok;
    logic [3:0] nwr;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{2'b10, 3'd0, 1'b0, 7'h00, 1'b0, 1'b0, 4'd1},  // empty slot, channel A
    '{2'b10, 3'd1, 1'b1, 7'h00, 1'b0, 1'b0, 4'd1},  // empty slot, channel B
    '{2'b10, 3'd2, 1'b0, 7'h50, 1'b0, 1'b1, 4'd7},  // valid frame
    '{2'b01, 3'd2, 1'b0, 7'h7F, 1'b1, 1'b1, 4'd1},  // transmit with conflict
    '{2'b11, 3'd2, 1'b1, 7'h7F, 1'b0, 1'b0, 4'd1},  // FIFO, invalid frame
    '{2'b01, 3'd3, 1'b1, 7'h00, 1'b0, 1'b0, 4'd1},  // transmit, no conflict
    '{2'b00, 3'd4, 1'b0, 7'h33, 1'b1, 1'b1, 4'd0},  // no buffer
    '{2'b11, 3'd7, 1'b0, 7'h55, 1'b0, 1'b1, 4'd7},  // FIFO valid, last buffer
    '{2'b01, 3'd7, 1'b0, 7'h00, 1'b1, 1'b0, 4'd1},
    '{2'b10, 3'd5, 1'b1, 7'h2A, 1'b1, 1'b1, 4'd7},
    '{2'b10, 3'd0, 1'b0, 7'h40, 1'b0, 1'b0, 4'd1},
    '{2'b01, 3'd0, 1'b0, 7'h00, 1'b1, 1'b0, 4'd1},
    '{2'b10, 3'd0, 1'b1, 7'h01, 1'b0, 1'b0, 4'd1}   // bit 0 must stay 1
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        slot_end;
  logic [1:0]  buf_kind;
  logic [2:0]  buf_sel;
  logic        ch_b;
  logic [6:0]  rx_flags;
  logic        tx_conflict;
  logic        frame_ok;
  logic        mt_tick;
  logic [2:0]  frm_idx;
  logic [15:0] frm_data;
  logic        ram_we;
  logic [5:0]  ram_addr;
  logic [15:0] ram_wdata;
  logic [15:0] ram_wmask;
  logic        busy;
  logic        done;
  logic        overrun;
  logic [3:0]  cur_tag;
  logic        fill;

  logic [15:0] mem     [NWORDS];
  logic [15:0] exp_mem [NWORDS];

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign frm_data = {4'hD, cur_tag, 5'd0, frm_idx};

  slotwb_ctrl #(
    .NUM_BUFS  (NUM_BUFS),
    .HDR_WORDS (HDR_WORDS),
    .PAY_WORDS (PAY_WORDS)
  ) u_dut (
    .clk         (clk),
    .rst         (rst),
    .slot_end    (slot_end),
    .buf_kind    (buf_kind),
    .buf_sel     (buf_sel),
    .ch_b        (ch_b),
    .rx_flags    (rx_flags),
    .tx_conflict (tx_conflict),
    .frame_ok    (frame_ok),
    .mt_tick     (mt_tick),
    .frm_idx     (frm_idx),
    .frm_data    (frm_data),
    .ram_we      (ram_we),
    .ram_addr    (ram_addr),
    .ram_wdata   (ram_wdata),
    .ram_wmask   (ram_wmask),
    .busy        (busy),
    .done        (done),
    .overrun     (overrun)
  );

  // Bench-owned buffer RAM with per-bit write mask.
  always @(posedge clk) begin
    if (fill) begin
      for (int i = 0; i < NWORDS; i++) mem[i] <= 16'h5A00 ^ 16'(i);
    end else if (ram_we && int'(ram_addr) < NWORDS) begin
      mem[ram_addr] <= (mem[ram_addr] & ~ram_wmask) | (ram_wdata & ram_wmask);
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cmp_ram(input string req);
    int bad_i = -1;
    for (int i = 0; i < NWORDS; i++)
      if (bad_i < 0 && mem[i] !== exp_mem[i]) bad_i = i;
    if (bad_i < 0) chk(1'b1, req, 32'd0, 32'd0);
    else chk(1'b0, {req, " ram word mismatch"}, {16'(bad_i), mem[bad_i]},
             {16'(bad_i), exp_mem[bad_i]});
  endtask

  // Expected effect of one slot outcome on the buffer RAM.
  task automatic model_update(input vec_t v, input logic [3:0] tag, input int nwords);
    int base = int'(v.bsel) * WPB;
    case (v.kind)
      2'b01: exp_mem[base][0] = v.txc;
      2'b10, 2'b11: begin
        exp_mem[base] = {7'b0, v.ch, v.fl, exp_mem[base][0]};
        if (v.ok)
          for (int k = 0; k < nwords; k++)
            exp_mem[base + 1 + k] = {4'hD, tag, 5'd0, 3'(k)};
      end
      default: ;
    endcase
  endtask

  task automatic drive_slot(input vec_t v, input logic [3:0] tag, input bit same_tick);
    buf_kind    = v.kind;
    buf_sel     = v.bsel;
    ch_b        = v.ch;
    rx_flags    = v.fl;
    tx_conflict = v.txc;
    frame_ok    = v.ok;
    cur_tag     = tag;
    slot_end    = 1'b1;
    mt_tick     = same_tick;
  endtask

  // Called at a negedge: pulse a tick, then watch ten cycles.
  task automatic tick_and_watch(output int nwr, output int first_c,
                                output int done_c, output int ndone);
    nwr = 0; first_c = -1; done_c = -1; ndone = 0;
    mt_tick = 1'b1;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (c == 0) mt_tick = 1'b0;
      if (ram_we) begin
        if (first_c < 0) first_c = c;
        nwr++;
      end
      if (done) begin
        ndone++;
        done_c = c;
      end
    end
  endtask

  task automatic run_vec(input vec_t v, input logic [3:0] tag, input bit same_tick);
    int nwr, first_c, done_c, ndone;
    int base = int'(v.bsel) * WPB;
    logic b0 = mem[base][0];
    string req;
    case (v.kind)
      2'b01:   req = "R2";
      2'b00:   req = "R10";
      default: req = v.ok ? "R5" : "R4";
    endcase
    @(negedge clk);
    drive_slot(v, tag, same_tick);
    @(negedge clk);
    slot_end = 1'b0;
    mt_tick  = 1'b0;
    chk(busy == (v.kind != 2'b00), (v.kind == 2'b00) ? "R10 busy" : "R8 busy",
        32'(busy), 32'(v.kind != 2'b00));
    for (int w = 0; w < 2; w++) begin
      chk(!ram_we, "R6 write before tick", 32'(ram_we), 32'd0);
      @(negedge clk);
    end
    tick_and_watch(nwr, first_c, done_c, ndone);
    chk(nwr == int'(v.nwr), {req, " write count"}, 32'(nwr), 32'(v.nwr));
    if (v.nwr != 0) begin
      chk(first_c == 0, "R6 first write cycle", 32'(first_c), 32'd0);
      chk(ndone == 1 && done_c == nwr, "R8 done pulse", {16'(ndone), 16'(done_c)},
          {16'd1, 16'(nwr)});
    end else begin
      chk(ndone == 0, "R10 done", 32'(ndone), 32'd0);
    end
    model_update(v, tag, DW);
    cmp_ram(req);
    if (v.kind[1]) begin
      chk(mem[base][0] == b0, "R3 bit0 kept", 32'(mem[base][0]), 32'(b0));
      chk(mem[base][15:9] == 7'b0, "R1 reserved zero", 32'(mem[base][15:9]), 32'd0);
      chk(mem[base][8:1] == {v.ch, v.fl}, "R1 field layout", 32'(mem[base][8:1]),
          32'({v.ch, v.fl}));
      if (v.fl == 7'd0 && !v.ok)
        chk({mem[base][15:1], 1'b0} == (v.ch ? 16'h0100 : 16'h0000), "R7 empty slot",
            32'({mem[base][15:1], 1'b0}), v.ch ? 32'h0100 : 32'h0000);
    end else if (v.kind == 2'b01) begin
      chk(mem[base][0] == v.txc, "R2 conflict bit", 32'(mem[base][0]), 32'(v.txc));
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=<%0d", WATCHDOG, WATCHDOG);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    vec_t d;
    int nwr, first_c, done_c, ndone;
    rst = 1'b1; fill = 1'b1; slot_end = 1'b0; buf_kind = 2'b00; buf_sel = '0;
    ch_b = 1'b0; rx_flags = '0; tx_conflict = 1'b0; frame_ok = 1'b0; mt_tick = 1'b0;
    cur_tag = '0;
    for (int i = 0; i < NWORDS; i++) exp_mem[i] = 16'h5A00 ^ 16'(i);
    repeat (3) @(negedge clk);
    rst = 1'b0; fill = 1'b0;
    @(negedge clk);

    // R11: state after reset.
    chk(!busy, "R11 reset busy", 32'(busy), 32'd0);
    chk(!done, "R11 reset done", 32'(done), 32'd0);
    chk(!ram_we, "R11 reset ram_we", 32'(ram_we), 32'd0);
    chk(!overrun, "R11 reset overrun", 32'(overrun), 32'd0);

    // Vector table.
    for (int i = 0; i < NV; i++) run_vec(VECS[i], 4'(i), 1'b0);

    // R6: a tick in the slot_end cycle does not start the write-back.
    run_vec('{2'b10, 3'd3, 1'b0, 7'h11, 1'b0, 1'b1, 4'd7}, 4'hE, 1'b1);

    // R9: second slot end while pending is dropped and flagged.
    d = '{2'b10, 3'd1, 1'b0, 7'h22, 1'b0, 1'b1, 4'd7};
    @(negedge clk);
    drive_slot(d, 4'h9, 1'b0);
    @(negedge clk);
    drive_slot('{2'b01, 3'd4, 1'b0, 7'h00, 1'b1, 1'b0, 4'd1}, 4'h9, 1'b0);
    @(negedge clk);
    slot_end = 1'b0;
    chk(overrun, "R9 overrun set", 32'(overrun), 32'd1);
    tick_and_watch(nwr, first_c, done_c, ndone);
    chk(nwr == WPB, "R9 only first event written", 32'(nwr), 32'(WPB));
    model_update(d, 4'h9, DW);
    cmp_ram("R9");
    chk(overrun, "R9 overrun sticky", 32'(overrun), 32'd1);

    // R11: reset in the middle of the data burst.
    d = '{2'b10, 3'd6, 1'b1, 7'h0F, 1'b0, 1'b1, 4'd7};
    @(negedge clk);
    drive_slot(d, 4'h6, 1'b0);
    @(negedge clk);
    slot_end = 1'b0;
    mt_tick  = 1'b1;
    @(negedge clk);
    mt_tick  = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!busy && !ram_we && !done, "R11 abort outputs", {busy, ram_we, done}, 32'd0);
    chk(!overrun, "R11 overrun cleared", 32'(overrun), 32'd0);
    model_update(d, 4'h6, 1);
    cmp_ram("R11");
    tick_and_watch(nwr, first_c, done_c, ndone);
    chk(nwr == 0 && ndone == 0, "R11 nothing pending", {16'(nwr), 16'(ndone)}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule